// File: doc/BRIEF.md
# Reset Boot-Source Selector

This block settles, after every reset, where the core takes its first instruction: address zero of the boot ROM or address zero of the flash program memory. An external high-voltage detector on an override pin raises a digital flag. If that flag is present during reset and stays present for a short hold window after reset is let go, the boot ROM wins regardless of the option register. Otherwise the flex bit of the option register makes the choice. At the end of the hold window the choice appears on a select output, together with a one-cycle start strobe.

While the high-voltage flag is up, the block enables a load clock onto a neighbouring pin, where it serves as the shift clock for the serial programming routine. The in-system programming enable is given only after an override boot, and only once the digital reading of the override pin has been low long enough to pass a debounce. The block also keeps the flex and security option bits, with write, page-erase and mass-erase requests. A software exit request starts an internal reset of fixed length. That reset is combined with the external reset and is followed by a fresh boot decision in which the override plays no part.

All timing is counted in instruction cycles, one per rising edge of `clk`.

Top module: `boot_source_ctrl`

## Requirements
- R1: While `reset_n_pin` is sampled low, `core_reset` is 1. One edge later, `boot_rom_sel`, `start_strobe` and `isp_en` are all 0.
- R2: Call E0 the first edge at which every reset is sampled released, and E1 and E2 the two edges after it. If `hv_detect` was 1 in the last cycle of an external reset and is 1 at E0, E1 and E2, then after E2 `boot_rom_sel` is 1 (boot ROM), whatever the flex bit holds.
- R3: If `hv_detect` is 0 at any of E0, E1 or E2, or was 0 during the reset, no override takes place and the flex-bit rule of R4 decides.
- R4: Without an override, `boot_rom_sel` becomes 0 (flash) when `opt_flex` is 1, and 1 (boot ROM) when `opt_flex` is 0.
- R5: `boot_rom_sel` changes only at E2, or on an external reset. `start_strobe` is 1 for exactly the one cycle after E2.
- R6: `load_clk_en` is a one-cycle-delayed copy of `hv_detect`. It is 0 after any edge at which the internal exit reset is active. In particular it is 0 one edge after reset is sampled low with `hv_detect` at 0.
- R7: `isp_en` is set only after an override boot, by the 16th consecutive low sample of `ovr_pin_in` after E2. A high sample restarts the count. `isp_en` is cleared by any reset.
- R8: Reset and the high-voltage override leave `opt_flex` and `opt_sec` unchanged.
- R9: The option bits change one edge after a request. `opt_wr` loads both bits from `opt_wr_flex` and `opt_wr_sec`. `erase_page` clears only `opt_flex`. `erase_mass` clears both bits. Priority is mass erase, then page erase, then write.
- R10: An `exit_req` sampled while no reset is active holds `core_reset` at 1 for exactly 4 cycles, starting at the next edge. The decision that follows ignores `hv_detect`. An `exit_req` sampled during an external reset is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| reset_n_pin | input | 1 | External reset, active low, sampled synchronously |
| hv_detect | input | 1 | Flag from the high-voltage detector on the override pin |
| ovr_pin_in | input | 1 | Digital reading of the override pin |
| exit_req | input | 1 | Software request to leave programming mode |
| opt_wr | input | 1 | Write strobe for the option bits |
| opt_wr_flex | input | 1 | Flex value to write |
| opt_wr_sec | input | 1 | Security value to write |
| erase_page | input | 1 | Page-erase request (clears flex) |
| erase_mass | input | 1 | Mass-erase request (clears flex and security) |
| core_reset | output | 1 | Combined reset to the core, active high |
| boot_rom_sel | output | 1 | 1 = start in boot ROM, 0 = start in flash |
| start_strobe | output | 1 | One-cycle pulse when the start location is valid |
| load_clk_en | output | 1 | Enables the load clock onto the neighbouring pin |
| isp_en | output | 1 | In-system programming enabled |
| opt_flex | output | 1 | Stored flex bit |
| opt_sec | output | 1 | Stored security bit |

## Verification
Three results come from registers and are due one edge after the stimulus that causes them: the load-clock enable, the option bits, and the clearing of reset-controlled outputs. The boot decision is due two edges after E0, so the select and strobe are read after E1, to confirm nothing has happened yet, and again after E2 and E3. The ISP enable is read just before and just after the sixteenth low sample. The exit reset is checked at each of its four cycles and at the first cycle after it, and the new decision is read three edges after that. The bench drives and samples one nanosecond after each rising edge, so every read falls between edges on settled values.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

    localparam int unsigned HOLD_CYC_DEF = 3;
    localparam int unsigned DEB_CYC_DEF  = 16;
    localparam int unsigned EXIT_CYC_DEF = 4;

    typedef enum logic [1:0] {
        PH_RESET = 2'd0,
        PH_HOLD  = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    typedef struct packed {
        logic rom;   // 1: boot ROM, 0: flash
        logic ovr;   // override accepted
    } boot_dec_t;

    typedef struct packed {
        logic flex;
        logic sec;
    } opt_bits_t;

    // Override wins; otherwise a cleared flex bit falls back to ROM.
    function automatic boot_dec_t decide_boot(input logic ovr_ok, input logic flex);
        boot_dec_t d;
        d.ovr = ovr_ok;
        d.rom = ovr_ok | ~flex;
        return d;
    endfunction

    function automatic opt_bits_t next_opt(
        input opt_bits_t cur,
        input logic      wr,
        input opt_bits_t wdata,
        input logic      pg_erase,
        input logic      ms_erase
    );
        opt_bits_t n;
        n = cur;
        if (ms_erase) begin
            n.flex = 1'b0;
            n.sec  = 1'b0;
        end else if (pg_erase) begin
            n.flex = 1'b0;
        end else if (wr) begin
            n = wdata;
        end
        return n;
    endfunction

endpackage

// File: rtl/bsel_exit_reset.sv
module bsel_exit_reset #(
    parameter int unsigned EXIT_CYC = boot_sel_pkg::EXIT_CYC_DEF
) (
    input  logic clk,
    input  logic ext_rst_n,
    input  logic exit_req,
    output logic exit_active
);
    localparam int unsigned CW = $clog2(EXIT_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!ext_rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (exit_req) begin
            cnt_q <= CW'(EXIT_CYC);
        end
    end

    assign exit_active = (cnt_q != '0);
endmodule

// File: rtl/bsel_window.sv
module bsel_window
    import boot_sel_pkg::*;
#(
    parameter int unsigned HOLD_CYC = HOLD_CYC_DEF
) (
    input  logic clk,
    input  logic ext_rst_n,
    input  logic exit_active,
    input  logic hv_detect,
    input  logic flex,
    output logic boot_rom_sel,
    output logic start_strobe,
    output logic ovr_active,
    output logic in_run
);
    localparam int unsigned CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic          hv_q;
    logic          sel_q;
    logic          strobe_q;
    logic          ovr_q;
    logic          rst_any;
    logic          hv_ok;
    boot_dec_t     dec;

    assign rst_any = !ext_rst_n || exit_active;
    assign hv_ok   = hv_q & hv_detect;
    assign dec     = decide_boot(hv_ok, flex);

    always_ff @(posedge clk) begin
        strobe_q <= 1'b0;
        if (rst_any) begin
            phase_q <= PH_RESET;
            cnt_q   <= '0;
            ovr_q   <= 1'b0;
            // only an external reset may arm the override
            hv_q    <= ext_rst_n ? 1'b0 : hv_detect;
            if (!ext_rst_n) begin
                sel_q <= 1'b0;
            end
        end else begin
            unique case (phase_q)
                PH_RESET, PH_HOLD: begin
                    hv_q <= hv_ok;
                    if (cnt_q == LAST) begin
                        sel_q    <= dec.rom;
                        ovr_q    <= dec.ovr;
                        strobe_q <= 1'b1;
                        phase_q  <= PH_RUN;
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                        phase_q <= PH_HOLD;
                    end
                end
                PH_RUN: begin
                    phase_q <= PH_RUN;
                end
                default: begin
                    phase_q <= PH_RESET;
                end
            endcase
        end
    end

    assign boot_rom_sel = sel_q;
    assign start_strobe = strobe_q;
    assign ovr_active   = ovr_q;
    assign in_run       = (phase_q == PH_RUN);
endmodule

// File: rtl/bsel_debounce.sv
module bsel_debounce #(
    parameter int unsigned DEB_CYC = boot_sel_pkg::DEB_CYC_DEF
) (
    input  logic clk,
    input  logic rst_any,
    input  logic enable,
    input  logic pin_in,
    output logic isp_en
);
    localparam int unsigned CW = $clog2(DEB_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          en_q;

    always_ff @(posedge clk) begin
        if (rst_any) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else if (enable && !en_q) begin
            if (pin_in) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                en_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign isp_en = en_q;
endmodule

// File: rtl/bsel_option_bits.sv
module bsel_option_bits
    import boot_sel_pkg::*;
(
    input  logic clk,
    input  logic wr,
    input  logic wr_flex,
    input  logic wr_sec,
    input  logic pg_erase,
    input  logic ms_erase,
    output logic flex,
    output logic sec
);
    opt_bits_t bits_q;
    opt_bits_t wdata;

    assign wdata = '{flex: wr_flex, sec: wr_sec};

    // Non-volatile contents: no reset of any kind touches them.
    always_ff @(posedge clk) begin
        bits_q <= next_opt(bits_q, wr, wdata, pg_erase, ms_erase);
    end

    assign flex = bits_q.flex;
    assign sec  = bits_q.sec;
endmodule

// File: rtl/boot_source_ctrl.sv
module boot_source_ctrl
    import boot_sel_pkg::*;
#(
    parameter int unsigned HOLD_CYC = HOLD_CYC_DEF,
    parameter int unsigned DEB_CYC  = DEB_CYC_DEF,
    parameter int unsigned EXIT_CYC = EXIT_CYC_DEF
) (
    input  logic clk,
    input  logic reset_n_pin,
    input  logic hv_detect,
    input  logic ovr_pin_in,
    input  logic exit_req,
    input  logic opt_wr,
    input  logic opt_wr_flex,
    input  logic opt_wr_sec,
    input  logic erase_page,
    input  logic erase_mass,
    output logic core_reset,
    output logic boot_rom_sel,
    output logic start_strobe,
    output logic load_clk_en,
    output logic isp_en,
    output logic opt_flex,
    output logic opt_sec
);
    logic exit_active;
    logic ovr_active;
    logic in_run;
    logic ldclk_q;

    assign core_reset = !reset_n_pin || exit_active;

    bsel_exit_reset #(.EXIT_CYC(EXIT_CYC)) exit_i (
        .clk         (clk),
        .ext_rst_n   (reset_n_pin),
        .exit_req    (exit_req),
        .exit_active (exit_active)
    );

    bsel_window #(.HOLD_CYC(HOLD_CYC)) win_i (
        .clk          (clk),
        .ext_rst_n    (reset_n_pin),
        .exit_active  (exit_active),
        .hv_detect    (hv_detect),
        .flex         (opt_flex),
        .boot_rom_sel (boot_rom_sel),
        .start_strobe (start_strobe),
        .ovr_active   (ovr_active),
        .in_run       (in_run)
    );

    bsel_debounce #(.DEB_CYC(DEB_CYC)) deb_i (
        .clk     (clk),
        .rst_any (core_reset),
        .enable  (in_run && ovr_active),
        .pin_in  (ovr_pin_in),
        .isp_en  (isp_en)
    );

    bsel_option_bits opt_i (
        .clk      (clk),
        .wr       (opt_wr),
        .wr_flex  (opt_wr_flex),
        .wr_sec   (opt_wr_sec),
        .pg_erase (erase_page),
        .ms_erase (erase_mass),
        .flex     (opt_flex),
        .sec      (opt_sec)
    );

    // Load clock follows the detector flag, silenced during an exit reset.
    always_ff @(posedge clk) begin
        if (exit_active) begin
            ldclk_q <= 1'b0;
        end else begin
            ldclk_q <= hv_detect;
        end
    end

    assign load_clk_en = ldclk_q;
endmodule

// File: rtl/boot_source_ctrl_chk.sv
module boot_source_ctrl_chk #(
    parameter int unsigned DEB_CYC  = boot_sel_pkg::DEB_CYC_DEF,
    parameter int unsigned EXIT_CYC = boot_sel_pkg::EXIT_CYC_DEF
) (
    input logic clk,
    input logic reset_n_pin,
    input logic hv_detect,
    input logic ovr_pin_in,
    input logic exit_req,
    input logic opt_wr,
    input logic erase_page,
    input logic erase_mass,
    input logic core_reset,
    input logic boot_rom_sel,
    input logic start_strobe,
    input logic load_clk_en,
    input logic isp_en,
    input logic opt_flex,
    input logic opt_sec
);
    localparam int unsigned LW = $clog2(DEB_CYC + 1);
    localparam int unsigned RW = $clog2(EXIT_CYC + 2);

    logic          started = 1'b0;
    logic [LW-1:0] low_run = '0;
    logic [RW-1:0] rst_run = '0;

    always_ff @(posedge clk) begin
        started <= 1'b1;
        if (ovr_pin_in) begin
            low_run <= '0;
        end else if (low_run != LW'(DEB_CYC)) begin
            low_run <= low_run + 1'b1;
        end
        if (!(core_reset && reset_n_pin)) begin
            rst_run <= '0;
        end else if (rst_run != RW'(EXIT_CYC + 1)) begin
            rst_run <= rst_run + 1'b1;
        end
    end

    assert_ext_reset_R1: assert property (@(posedge clk) disable iff (!started)
        !reset_n_pin |-> core_reset);

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!started)
        !reset_n_pin |=> (!boot_rom_sel && !start_strobe && !isp_en));

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!started || !reset_n_pin)
        start_strobe |=> !start_strobe);

    assert_sel_only_at_window_R5: assert property (@(posedge clk) disable iff (!started || !reset_n_pin)
        ($past(reset_n_pin) && $changed(boot_rom_sel)) |-> start_strobe);

    assert_ldclk_quiet_R6: assert property (@(posedge clk) disable iff (!started)
        (!reset_n_pin && !hv_detect) |=> !load_clk_en);

    assert_isp_debounced_R7: assert property (@(posedge clk) disable iff (!started || !reset_n_pin)
        $rose(isp_en) |-> (low_run >= LW'(DEB_CYC)));

    assert_opt_hold_R8: assert property (@(posedge clk) disable iff (!started)
        (!opt_wr && !erase_page && !erase_mass) |=> ($stable(opt_flex) && $stable(opt_sec)));

    assert_mass_erase_R9: assert property (@(posedge clk) disable iff (!started)
        erase_mass |=> (!opt_flex && !opt_sec));

    assert_exit_starts_R10: assert property (@(posedge clk) disable iff (!started || !reset_n_pin)
        (exit_req && !core_reset) |=> core_reset);

    assert_exit_length_R10: assert property (@(posedge clk) disable iff (!started)
        rst_run <= RW'(EXIT_CYC));
endmodule

bind boot_source_ctrl boot_source_ctrl_chk #(
    .DEB_CYC  (DEB_CYC),
    .EXIT_CYC (EXIT_CYC)
) chk_i (
    .clk          (clk),
    .reset_n_pin  (reset_n_pin),
    .hv_detect    (hv_detect),
    .ovr_pin_in   (ovr_pin_in),
    .exit_req     (exit_req),
    .opt_wr       (opt_wr),
    .erase_page   (erase_page),
    .erase_mass   (erase_mass),
    .core_reset   (core_reset),
    .boot_rom_sel (boot_rom_sel),
    .start_strobe (start_strobe),
    .load_clk_en  (load_clk_en),
    .isp_en       (isp_en),
    .opt_flex     (opt_flex),
    .opt_sec      (opt_sec)
);

// File: tb/boot_source_ctrl_tb_top.sv
module boot_source_ctrl_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    logic clk = 1'b0;
    logic reset_n_pin = 1'b0;
    logic hv_detect = 1'b0;
    logic ovr_pin_in = 1'b1;
    logic exit_req = 1'b0;
    logic opt_wr = 1'b0;
    logic opt_wr_flex = 1'b0;
    logic opt_wr_sec = 1'b0;
    logic erase_page = 1'b0;
    logic erase_mass = 1'b0;
    logic core_reset, boot_rom_sel, start_strobe, load_clk_en, isp_en, opt_flex, opt_sec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    boot_source_ctrl dut_i (
        .clk          (clk),
        .reset_n_pin  (reset_n_pin),
        .hv_detect    (hv_detect),
        .ovr_pin_in   (ovr_pin_in),
        .exit_req     (exit_req),
        .opt_wr       (opt_wr),
        .opt_wr_flex  (opt_wr_flex),
        .opt_wr_sec   (opt_wr_sec),
        .erase_page   (erase_page),
        .erase_mass   (erase_mass),
        .core_reset   (core_reset),
        .boot_rom_sel (boot_rom_sel),
        .start_strobe (start_strobe),
        .load_clk_en  (load_clk_en),
        .isp_en       (isp_en),
        .opt_flex     (opt_flex),
        .opt_sec      (opt_sec)
    );

    // {hv during reset, edges from E0 with hv high [2:0], flex, expected rom select}
    localparam logic [5:0] VECS [8] = '{
        6'b1_011_1_1,   // full hold, flex=1 -> ROM        (R2)
        6'b1_011_0_1,   // full hold, flex=0 -> ROM        (R2)
        6'b1_010_1_0,   // drops at E2, flex=1 -> flash    (R3)
        6'b1_010_0_1,   // drops at E2, flex=0 -> ROM      (R3)
        6'b0_011_1_0,   // not seen in reset -> flex rule  (R3)
        6'b0_000_0_1,   // plain, flex=0 -> ROM            (R4)
        6'b1_000_1_0,   // drops at E0, flex=1 -> flash    (R3)
        6'b1_101_1_1    // held past window -> ROM         (R2)
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Reset with given hv, release, hold hv for hold_n edges from E0, check decision at E2.
    task automatic boot_seq(input logic hv_rst, input int hold_n, input logic flex, input logic exp_rom);
        reset_n_pin = 1'b0;
        hv_detect   = hv_rst;
        opt_wr = 1'b1; opt_wr_flex = flex; opt_wr_sec = 1'b1;
        tick();
        opt_wr = 1'b0;
        tick();
        check("R1", "core_reset in reset", core_reset, 1'b1);
        check("R1", "select in reset", boot_rom_sel, 1'b0);
        check("R1", "strobe in reset", start_strobe, 1'b0);
        check("R1", "isp_en in reset", isp_en, 1'b0);
        reset_n_pin = 1'b1;
        hv_detect   = (hold_n > 0);
        tick();                                  // E0
        for (int k = 1; k < 3; k++) begin
            hv_detect = (k < hold_n);
            check("R5", "strobe before window end", start_strobe, 1'b0);
            tick();                              // E1, E2
        end
        check("R5", "strobe at window end", start_strobe, 1'b1);
        check(exp_rom ? "R2" : "R4", "select at window end", boot_rom_sel, exp_rom);
        tick();
        check("R5", "strobe one cycle only", start_strobe, 1'b0);
        check("R5", "select held", boot_rom_sel, exp_rom);
        hv_detect = 1'b0;
    endtask

    initial begin
        #(5ns * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // table walk: R2, R3, R4, R5, R1
        for (int i = 0; i < 8; i++) begin
            boot_seq(VECS[i][5], int'(VECS[i][4:2]), VECS[i][1], VECS[i][0]);
        end

        // R6: load clock follows detector, quiet in reset without hv
        reset_n_pin = 1'b0; hv_detect = 1'b0;
        tick();
        check("R6", "load clock quiet in reset", load_clk_en, 1'b0);
        hv_detect = 1'b1;
        tick();
        check("R6", "load clock with hv", load_clk_en, 1'b1);
        hv_detect = 1'b0;
        tick();
        check("R6", "load clock follows drop", load_clk_en, 1'b0);

        // R7: no override -> never enabled
        boot_seq(1'b0, 0, 1'b1, 1'b0);
        ovr_pin_in = 1'b0;
        repeat (20) tick();
        check("R7", "isp without override", isp_en, 1'b0);
        ovr_pin_in = 1'b1;

        // R7/R8: override boot, debounce with a restart
        boot_seq(1'b1, 3, 1'b1, 1'b1);
        check("R8", "flex kept after override", opt_flex, 1'b1);
        check("R8", "sec kept after override", opt_sec, 1'b1);
        repeat (3) tick();
        check("R7", "isp while pin high", isp_en, 1'b0);
        ovr_pin_in = 1'b0;
        repeat (10) tick();
        check("R7", "isp after 10 lows", isp_en, 1'b0);
        ovr_pin_in = 1'b1;
        tick();
        ovr_pin_in = 1'b0;
        repeat (15) tick();
        check("R7", "isp after restart and 15 lows", isp_en, 1'b0);
        tick();
        check("R7", "isp after 16 lows", isp_en, 1'b1);

        // R10: exit reset, hv high throughout must be ignored
        hv_detect = 1'b1;
        exit_req  = 1'b1;
        tick();                                  // Ex
        exit_req  = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check("R10", "core_reset during exit", core_reset, 1'b1);
            if (k == 1) begin
                check("R7", "isp cleared by exit reset", isp_en, 1'b0);
                check("R6", "load clock off in exit reset", load_clk_en, 1'b0);
            end
            tick();
        end
        check("R10", "core_reset after 4 cycles", core_reset, 1'b0);
        check("R5", "select held through exit reset", boot_rom_sel, 1'b1);
        tick();
        tick();
        check("R5", "strobe before re-decision", start_strobe, 1'b0);
        tick();
        check("R10", "strobe after exit", start_strobe, 1'b1);
        check("R10", "flash after exit", boot_rom_sel, 1'b0);
        hv_detect  = 1'b0;
        ovr_pin_in = 1'b1;
        tick();

        // R9: option bit requests
        erase_page = 1'b1;
        tick();
        erase_page = 1'b0;
        check("R9", "page erase clears flex", opt_flex, 1'b0);
        check("R9", "page erase keeps sec", opt_sec, 1'b1);
        opt_wr = 1'b1; opt_wr_flex = 1'b1; opt_wr_sec = 1'b0; erase_mass = 1'b1;
        tick();
        opt_wr = 1'b0; erase_mass = 1'b0;
        check("R9", "mass erase wins flex", opt_flex, 1'b0);
        check("R9", "mass erase wins sec", opt_sec, 1'b0);
        opt_wr = 1'b1; opt_wr_flex = 1'b1; opt_wr_sec = 1'b1;
        tick();
        opt_wr = 1'b0;
        check("R9", "write flex", opt_flex, 1'b1);
        check("R9", "write sec", opt_sec, 1'b1);
        reset_n_pin = 1'b0;
        repeat (3) tick();
        check("R8", "flex kept over reset", opt_flex, 1'b1);

        // R10: exit request during external reset ignored
        exit_req = 1'b1;
        tick();
        exit_req    = 1'b0;
        reset_n_pin = 1'b1;
        tick();
        check("R10", "exit ignored in reset", core_reset, 1'b0);
        repeat (3) tick();

        finish_run();
    end
endmodule